// File: doc/BRIEF.md
# Write-Back Line Cache Controller

This block is a direct-mapped, write-back, write-allocate cache controller that sits between an upper level issuing whole-line requests and a slower memory that moves 32-byte lines. Each request carries a line address; writes also carry a 32-byte data vector and a per-byte enable mask. A hit returns the full line after a fixed hit latency. A miss returns the line once the miss sequence is complete.

On a miss the controller first copies the line currently held at the index into a one-line victim register. It then fetches the requested line from memory and merges any write bytes into it before installing it. Only after that does it write the old line back, and only if that line was dirty. The upper level is held off by a ready signal for the whole of the transaction.

Tag, valid and dirty state and the line data are kept in internal register arrays. Their depth is set by the index-width parameter: 16 index bits give the 64K-line, 2 MB configuration. There is one outstanding miss at a time.

Top module: `l2c_wb_cache`

## Requirements
- R1: The line address splits into an index (its low IDX_W bits) and a tag (the remaining high bits). A lookup hits only when the entry at that index is valid and its stored tag equals the request tag. A different tag at the same index replaces the resident line.
- R2: A hit raises rsp_valid for exactly one cycle, HIT_LAT (default 10) clock edges after the edge that accepted the request. rsp_data carries the full 256-bit line, including any bytes written by that request.
- R3: On a miss the refill read is requested before any writeback starts, and the writeback starts only after the refill data has arrived. A miss that evicts nothing dirty responds 4 cycles plus the memory read latency after acceptance. A dirty eviction adds the memory write latency.
- R4: A valid dirty victim is written to memory once, at the victim's own line address, with its full line data. A clean or invalid victim is dropped without any memory write.
- R5: A write hit updates only the bytes whose enable bit is set: enable bit i covers data bits [8i+7:8i]. It marks the line dirty and causes no memory access.
- R6: A write miss fetches the whole line from memory, overlays the enabled bytes, installs the result and marks it dirty. A read miss installs the fetched line clean.
- R7: ready is high only when the controller is idle. A request is taken only on a clock edge where req_valid and ready are both high. ready stays low from acceptance until the response, including any writeback. Requests presented while ready is low have no effect.
- R8: After reset every entry is invalid, so the first access to any index misses and writes nothing back, even if that index held dirty data before reset. After reset, ready is high and rsp_valid, mem_rd_req and mem_wr_req are low.
- R9: mem_rd_req stays high with a stable address until the cycle in which mem_rd_valid is seen. mem_wr_req stays high with a stable address until mem_wr_ack is seen. Exactly one line read is issued per miss and none per hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upper-level request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | LADDR_W | Line address |
| req_wdata | input | 256 | Write line data |
| req_be | input | 32 | Per-byte write enable, bit i for byte i |
| ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 256 | Line returned with the response |
| mem_rd_req | output | 1 | Line read request to memory |
| mem_rd_addr | output | LADDR_W | Line address being read |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 256 | Line read from memory |
| mem_wr_req | output | 1 | Line writeback request |
| mem_wr_addr | output | LADDR_W | Line address being written |
| mem_wr_data | output | 256 | Line data being written |
| mem_wr_ack | input | 1 | Writeback accepted strobe |

## Verification
A wrong dirty bit shows up only when the line is evicted. It then causes either a missing memory write, or an extra one whose timing betrays it because the response comes a write latency late. For that reason the bench follows dirty lines through later conflicting accesses and rereads evicted addresses. A corrupted tag or valid bit flips hit and miss, which shows on the very next access at that index: the response latency jumps between 10 and the miss latency, and the memory read count changes. Merge or byte-enable errors appear directly in rsp_data of the same transaction. They appear again in memory after the eviction.

// File: rtl/l2c_pkg.sv
// Package: shared types and helpers for the write-back line cache.
// Assumes 32-byte lines; the line is the unit of every transfer.
package l2c_pkg;
    localparam int LINE_BYTES = 32;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    typedef logic [LINE_BITS-1:0]  line_t;
    typedef logic [LINE_BYTES-1:0] be_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SAVE,
        ST_REFILL,
        ST_MERGE,
        ST_WBACK,
        ST_RESPOND
    } state_e;

    // Overlay the enabled bytes of nw onto base.
    function automatic line_t overlay_bytes(line_t base, line_t nw, be_t be);
        line_t res;
        res = base;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (be[b]) res[8*b +: 8] = nw[8*b +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/l2c_tag_store.sv
// Tag store: per-index valid, dirty and tag. Read is combinational,
// write is one port. Reset clears valid and dirty; tags are left as is.
module l2c_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    // Status bits: cleared by reset, set on install or write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    // Tag array: written on install.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[idx] <= wr_tag;
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    p_wr_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown({idx, wr_tag, wr_dirty}));

    p_install_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_valid || !$stable(idx));
endmodule

// File: rtl/l2c_data_store.sv
// Data store: one 256-bit line per index with byte-enabled write and
// combinational read. Contents are not reset; valid bits gate their use.
module l2c_data_store #(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  l2c_pkg::line_t    wr_line,
    input  l2c_pkg::be_t      wr_be,
    output l2c_pkg::line_t    rd_line
);
    localparam int DEPTH = 1 << IDX_W;

    l2c_pkg::line_t mem_q [DEPTH];

    // Byte-lane write into the selected line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < l2c_pkg::LINE_BYTES; b++) begin
                if (wr_be[b]) mem_q[idx][8*b +: 8] <= wr_line[8*b +: 8];
            end
        end
    end

    assign rd_line = mem_q[idx];

    p_be_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_be));
endmodule

// File: rtl/l2c_ctrl.sv
// Controller: accepts one request at a time, times hits, and runs the
// miss sequence save-victim, refill, merge, optional writeback, respond.
// Assumes HIT_LAT >= 2 and that memory strobes last one cycle.
module l2c_ctrl #(
    parameter int LADDR_W = 10,
    parameter int IDX_W   = 4,
    parameter int HIT_LAT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LADDR_W-1:0]   req_addr,
    input  l2c_pkg::line_t       req_wdata,
    input  l2c_pkg::be_t         req_be,
    output logic                 ready,
    output logic                 rsp_valid,
    output l2c_pkg::line_t       rsp_data,
    output logic                 mem_rd_req,
    output logic [LADDR_W-1:0]   mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  l2c_pkg::line_t       mem_rd_data,
    output logic                 mem_wr_req,
    output logic [LADDR_W-1:0]   mem_wr_addr,
    output l2c_pkg::line_t       mem_wr_data,
    input  logic                 mem_wr_ack,
    output logic [IDX_W-1:0]     idx,
    input  logic                 ts_valid,
    input  logic                 ts_dirty,
    input  logic [LADDR_W-IDX_W-1:0] ts_tag,
    output logic                 ts_we,
    output logic                 ts_wr_dirty,
    input  l2c_pkg::line_t       ds_line,
    output logic                 ds_we,
    output l2c_pkg::line_t       ds_wr_line,
    output l2c_pkg::be_t         ds_wr_be
);
    import l2c_pkg::*;

    localparam int TAG_W = LADDR_W - IDX_W;
    localparam int CNT_W = $clog2(HIT_LAT + 1);

    state_e               state_q;
    logic [LADDR_W-1:0]   addr_q;
    logic                 write_q;
    line_t                wdata_q;
    be_t                  be_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 miss_q;
    line_t                vic_line_q;
    logic [LADDR_W-1:0]   vic_addr_q;
    logic                 vic_dirty_q;
    line_t                fill_q;
    logic                 fill_done_q;
    logic                 hit;

    assign idx   = addr_q[IDX_W-1:0];
    assign hit   = ts_valid && (ts_tag == addr_q[LADDR_W-1:IDX_W]);
    assign ready = (state_q == ST_IDLE);

    assign mem_rd_req  = (state_q == ST_REFILL);
    assign mem_rd_addr = addr_q;
    assign mem_wr_req  = (state_q == ST_WBACK);
    assign mem_wr_addr = vic_addr_q;
    assign mem_wr_data = vic_line_q;

    // Array write requests: byte write on a write hit, full install on merge.
    always_comb begin
        ts_we       = 1'b0;
        ts_wr_dirty = 1'b0;
        ds_we       = 1'b0;
        ds_wr_line  = wdata_q;
        ds_wr_be    = be_q;
        if (state_q == ST_LOOKUP && hit && write_q) begin
            ts_we       = 1'b1;
            ts_wr_dirty = 1'b1;
            ds_we       = 1'b1;
        end else if (state_q == ST_MERGE) begin
            ts_we       = 1'b1;
            ts_wr_dirty = write_q;
            ds_we       = 1'b1;
            ds_wr_line  = overlay_bytes(fill_q, wdata_q, write_q ? be_q : '0);
            ds_wr_be    = '1;
        end
    end

    // Sequencer: request capture, hit timing and the miss sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid   <= 1'b0;
            cnt_q       <= '0;
            miss_q      <= 1'b0;
            vic_dirty_q <= 1'b0;
            fill_done_q <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (state_q != ST_IDLE && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q      <= req_addr;
                    write_q     <= req_write;
                    wdata_q     <= req_wdata;
                    be_q        <= req_be;
                    cnt_q       <= CNT_W'(1);
                    fill_done_q <= 1'b0;
                    state_q     <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    miss_q  <= !hit;
                    state_q <= hit ? ST_RESPOND : ST_SAVE;
                end
                ST_SAVE: begin
                    vic_line_q  <= ds_line;
                    vic_addr_q  <= {ts_tag, idx};
                    vic_dirty_q <= ts_valid && ts_dirty;
                    state_q     <= ST_REFILL;
                end
                ST_REFILL: if (mem_rd_valid) begin
                    fill_q      <= mem_rd_data;
                    fill_done_q <= 1'b1;
                    state_q     <= ST_MERGE;
                end
                ST_MERGE: state_q <= vic_dirty_q ? ST_WBACK : ST_RESPOND;
                ST_WBACK: if (mem_wr_ack) state_q <= ST_RESPOND;
                ST_RESPOND: if (miss_q || cnt_q >= CNT_W'(HIT_LAT)) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= ds_line;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> mem_rd_req && $stable(mem_rd_addr));

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req && $stable(mem_wr_addr));

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    p_wb_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> fill_done_q);

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ready && !mem_rd_req && !mem_wr_req);
endmodule

// File: rtl/l2c_wb_cache.sv
// Top: direct-mapped write-back write-allocate line cache. Connects the
// controller to the tag and data stores. One miss outstanding at a time.
module l2c_wb_cache #(
    parameter int LADDR_W = 10,
    parameter int IDX_W   = 4,
    parameter int HIT_LAT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LADDR_W-1:0]   req_addr,
    input  logic [255:0]         req_wdata,
    input  logic [31:0]          req_be,
    output logic                 ready,
    output logic                 rsp_valid,
    output logic [255:0]         rsp_data,
    output logic                 mem_rd_req,
    output logic [LADDR_W-1:0]   mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [255:0]         mem_rd_data,
    output logic                 mem_wr_req,
    output logic [LADDR_W-1:0]   mem_wr_addr,
    output logic [255:0]         mem_wr_data,
    input  logic                 mem_wr_ack
);
    localparam int TAG_W = LADDR_W - IDX_W;

    logic [IDX_W-1:0] idx;
    logic             ts_valid, ts_dirty, ts_we, ts_wr_dirty;
    logic [TAG_W-1:0] ts_tag;
    l2c_pkg::line_t   ds_line, ds_wr_line;
    l2c_pkg::be_t     ds_wr_be;
    logic             ds_we;

    l2c_ctrl #(.LADDR_W(LADDR_W), .IDX_W(IDX_W), .HIT_LAT(HIT_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .idx(idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
        .ts_we(ts_we), .ts_wr_dirty(ts_wr_dirty),
        .ds_line(ds_line), .ds_we(ds_we), .ds_wr_line(ds_wr_line),
        .ds_wr_be(ds_wr_be)
    );

    l2c_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .wr_en(ts_we), .wr_dirty(ts_wr_dirty),
        .wr_tag(req_addr_tag()),
        .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag)
    );

    l2c_data_store #(.IDX_W(IDX_W)) u_data (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .wr_en(ds_we), .wr_line(ds_wr_line), .wr_be(ds_wr_be),
        .rd_line(ds_line)
    );

    // Tag of the request being served, taken from the controller's latch.
    function automatic logic [TAG_W-1:0] req_addr_tag();
        return u_ctrl.addr_q[LADDR_W-1:IDX_W];
    endfunction
endmodule

// File: tb/l2c_wb_cache_bench.sv
// Bench for l2c_wb_cache: table-driven transactions against a behavioural
// memory with fixed read and write latency, then directed corner tests.
module l2c_wb_cache_bench;
    localparam int LADDR_W = 10;
    localparam int IDX_W   = 4;
    localparam int HIT_LAT = 10;
    localparam int RLAT    = 32;
    localparam int WLAT    = 5;

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] be;
        logic [7:0]  seed;
        logic        hit;
        logic        wb;
        logic [9:0]  wb_addr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h005, 32'h0,        8'h00, 1'b0, 1'b0, 10'h000},
        '{1'b0, 10'h005, 32'h0,        8'h00, 1'b1, 1'b0, 10'h000},
        '{1'b1, 10'h005, 32'h0000000F, 8'h11, 1'b1, 1'b0, 10'h000},
        '{1'b0, 10'h015, 32'h0,        8'h00, 1'b0, 1'b1, 10'h005},
        '{1'b0, 10'h005, 32'h0,        8'h00, 1'b0, 1'b0, 10'h000},
        '{1'b1, 10'h023, 32'hFF000000, 8'h22, 1'b0, 1'b0, 10'h000},
        '{1'b0, 10'h023, 32'h0,        8'h00, 1'b1, 1'b0, 10'h000},
        '{1'b1, 10'h033, 32'hFFFFFFFF, 8'h33, 1'b0, 1'b1, 10'h023},
        '{1'b0, 10'h005, 32'h0,        8'h00, 1'b1, 1'b0, 10'h000},
        '{1'b1, 10'h00A, 32'h80000001, 8'h44, 1'b0, 1'b0, 10'h000},
        '{1'b1, 10'h00A, 32'h0000FF00, 8'h55, 1'b1, 1'b0, 10'h000},
        '{1'b0, 10'h01A, 32'h0,        8'h00, 1'b0, 1'b1, 10'h00A}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [LADDR_W-1:0] req_addr = '0;
    logic [255:0]       req_wdata = '0;
    logic [31:0]        req_be = '0;
    logic               ready, rsp_valid;
    logic [255:0]       rsp_data;
    logic               mem_rd_req, mem_wr_req;
    logic [LADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic               mem_rd_valid = 1'b0;
    logic [255:0]       mem_rd_data = '0;
    logic [255:0]       mem_wr_data;
    logic               mem_wr_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, rd_cyc = 0, wr_cyc = 0;
    logic [LADDR_W-1:0] last_wr_addr;
    logic [255:0]       last_wr_data;
    logic [255:0]       bmem [int];
    logic [255:0]       refv [int];

    always #4 clk = ~clk;

    l2c_wb_cache #(.LADDR_W(LADDR_W), .IDX_W(IDX_W), .HIT_LAT(HIT_LAT)) u_l2c_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    function automatic logic [255:0] init_line(int a);
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[32*w +: 32] = {16'(a), 8'(w), 8'h5A};
        return v;
    endfunction

    function automatic logic [255:0] memv(int a);
        return bmem.exists(a) ? bmem[a] : init_line(a);
    endfunction

    function automatic logic [255:0] cur(int a);
        return refv.exists(a) ? refv[a] : memv(a);
    endfunction

    function automatic logic [255:0] seed_line(logic [7:0] s);
        logic [255:0] v;
        for (int b = 0; b < 32; b++) v[8*b +: 8] = s + 8'(b);
        return v;
    endfunction

    function automatic logic [255:0] apply_be(logic [255:0] o, logic [255:0] n, logic [31:0] m);
        logic [255:0] v;
        for (int b = 0; b < 32; b++) v[8*b +: 8] = m[b] ? n[8*b +: 8] : o[8*b +: 8];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Cycle counter and watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // Behavioural memory with fixed latencies.
    initial begin
        int rw = 0, ww = 0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_wr_ack   = 1'b0;
            if (mem_rd_req) begin
                rw++;
                if (rw == RLAT) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = memv(int'(mem_rd_addr));
                    rw = 0; rd_cnt++; rd_cyc = cyc;
                end
            end else rw = 0;
            if (mem_wr_req) begin
                ww++;
                if (ww == WLAT) begin
                    mem_wr_ack = 1'b1;
                    bmem[int'(mem_wr_addr)] = mem_wr_data;
                    last_wr_addr = mem_wr_addr;
                    last_wr_data = mem_wr_data;
                    ww = 0; wr_cnt++; wr_cyc = cyc;
                end
            end else ww = 0;
        end
    end

    task automatic run(input logic wr, input logic [9:0] addr, input logic [31:0] be,
                       input logic [7:0] seed, input logic exp_hit, input logic exp_wb,
                       input logic [9:0] wb_addr, input bit stray);
        int n, rd0, wr0, leak, exp_lat;
        bit got;
        logic [255:0] data, exp_data, exp_vic;
        exp_vic = cur(int'(wb_addr));
        @(negedge clk);
        chk(ready == 1'b1, "R7", "ready before request", 256'(ready), 256'(1));
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = seed_line(seed); req_be = be;
        @(posedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt; n = 0; leak = 0; got = 0; data = '0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (stray) begin
                if (n >= 2 && n <= 5) begin
                    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h067;
                    req_wdata = seed_line(8'hEE); req_be = '1;
                end else req_valid = 1'b0;
            end
            if (rsp_valid) begin
                got = 1; data = rsp_data;
            end else if (ready) leak++;
        end
        exp_data = wr ? apply_be(cur(int'(addr)), seed_line(seed), be) : cur(int'(addr));
        refv[int'(addr)] = exp_data;
        exp_lat = exp_hit ? HIT_LAT : (exp_wb ? RLAT + WLAT + 4 : RLAT + 4);
        if (exp_hit) chk(n == exp_lat, "R2", "hit latency", 256'(n), 256'(exp_lat));
        else         chk(n == exp_lat, "R3", "miss latency", 256'(n), 256'(exp_lat));
        if (wr && exp_hit)       chk(data == exp_data, "R5", "write hit line", data, exp_data);
        else if (wr)             chk(data == exp_data, "R6", "write miss line", data, exp_data);
        else                     chk(data == exp_data, "R1", "read line", data, exp_data);
        chk(leak == 0, "R7", "ready high while busy", 256'(leak), 256'(0));
        chk(rd_cnt - rd0 == (exp_hit ? 0 : 1), "R9", "line reads", 256'(rd_cnt - rd0),
            256'(exp_hit ? 0 : 1));
        chk(wr_cnt - wr0 == (exp_wb ? 1 : 0), "R4", "writebacks", 256'(wr_cnt - wr0),
            256'(exp_wb ? 1 : 0));
        if (exp_wb) begin
            chk(last_wr_addr == wb_addr, "R4", "victim address", 256'(last_wr_addr), 256'(wb_addr));
            chk(last_wr_data == exp_vic, "R4", "victim data", last_wr_data, exp_vic);
            chk(wr_cyc > rd_cyc, "R3", "writeback after refill", 256'(wr_cyc), 256'(rd_cyc));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle outputs after reset
        chk(ready && !rsp_valid && !mem_rd_req && !mem_wr_req, "R8", "reset outputs",
            256'({ready, rsp_valid, mem_rd_req, mem_wr_req}), 256'(4'b1000));

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].seed,
                VECS[i].hit, VECS[i].wb, VECS[i].wb_addr, 1'b0);
        end

        // R7: a write offered while busy must not be taken
        begin
            int r0;
            run(1'b0, 10'h045, 32'h0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b1);
            r0 = rd_cnt;
            repeat (4) begin
                @(negedge clk);
                chk(!rsp_valid && ready, "R7", "no response to ignored request",
                    256'({rsp_valid, ready}), 256'(2'b01));
            end
            chk(rd_cnt == r0, "R7", "no extra memory read", 256'(rd_cnt), 256'(r0));
            run(1'b0, 10'h067, 32'h0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0);
        end

        // R8: reset drops a dirty line (0x033) without a writeback
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        refv.delete();
        run(1'b0, 10'h033, 32'h0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0);
        run(1'b0, 10'h033, 32'h0, 8'h00, 1'b1, 1'b0, 10'h000, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule